// File: doc/BRIEF.md
# Address Channel Rule Monitor

This block watches one address channel of an AXI3 interface, either the write or the read channel, and records each rule the master breaks. It samples the handshake pair and the whole address payload (ID, address, length, size, burst type, lock type, cache attributes and protection) on every rising clock edge. Each rule has its own error flag. A flag sets one clock after the offending cycle and stays set until the next reset.

The rules fall into four groups. The handshake rules require the payload and VALID to hold while a transfer waits for READY, and VALID to be low in the first cycle out of reset. The encoding rules reject the reserved burst and lock types and the illegal cache combinations. The geometry rules check the transfer size against the data bus width, check WRAP alignment and length, and detect INCR bursts that cross a 4KB address boundary. A separate warning flag reports a READY response that is too slow. An input mask suppresses any chosen rule. A one-hot output names the rule that fired first, so a failing run can be traced back to its first cause.

Top module: `addr_chan_monitor`

## Requirements
- R1: Reset is asynchronous and active low. While it is asserted, and in the first cycle after it, `err_o`, `first_err_o` and `wait_warn_o` are all zero. Every flag is registered, shows the cycle sampled at the previous rising edge, and stays set until reset.
- R2: If `valid_i` is high in the first clock cycle after `rst_ni` deasserts, bit 0 is set.
- R3: If `valid_i` was high and `ready_i` was low in the previous cycle, and `valid_i` is now low, bit 1 is set.
- R4: If `valid_i` was high and `ready_i` was low in the previous cycle, and `valid_i` is still high, a change in a field sets that field's bit. The bits are: id 2, addr 3, len 4, size 5, burst 6, lock 7, cache 8, prot 9. A change after a cycle in which `ready_i` was high is not an error.
- R5: While `valid_i` is high, `burst_i` = 2'b11 sets bit 10 and `lock_i` = 2'b11 sets bit 11. Neither is checked while `valid_i` is low.
- R6: While `valid_i` is high, `cache_i[1]` = 0 together with a nonzero `cache_i[3:2]` sets bit 12.
- R7: While `valid_i` is high, a transfer of 2^`size_i` bytes that is wider than DATA_W/8 bytes sets bit 13.
- R8: For a WRAP burst (`burst_i` = 2'b10), a start address not aligned to 2^`size_i` sets bit 14. A `len_i` other than 1, 3, 7 or 15 sets bit 15.
- R9: For an INCR burst (`burst_i` = 2'b01), bit 16 is set when the start address aligned down to the size and the last byte (aligned start + (`len_i`+1)·2^`size_i` − 1) fall in different 4KB regions. FIXED (2'b00) and WRAP bursts are exempt.
- R10: A rule whose bit is set in `err_mask_i` never sets its `err_o` bit and is never reported in `first_err_o`.
- R11: `first_err_o` is one-hot or zero. It takes the first unmasked rule that fires after reset, picks the lowest bit index when several fire in the same cycle, and then holds until reset.
- R12: `wait_warn_o` sets at the end of the MAX_WAITS-th consecutive cycle in which `valid_i` is high and `ready_i` is low. It is sticky until reset. With WAIT_WARN_EN = 0 it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Channel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Address valid from master |
| ready_i | input | 1 | Address ready from slave |
| id_i | input | ID_W | Transaction ID |
| addr_i | input | ADDR_W | Start address |
| len_i | input | 4 | Beats minus one |
| size_i | input | 3 | Log2 of bytes per beat |
| burst_i | input | 2 | Burst type |
| lock_i | input | 2 | Lock type |
| cache_i | input | 4 | Cache attributes |
| prot_i | input | 3 | Protection attributes |
| err_mask_i | input | 17 | Per-rule suppression |
| err_o | output | 17 | Sticky per-rule error flags |
| first_err_o | output | 17 | One-hot first error |
| wait_warn_o | output | 1 | Sticky slow-READY warning |

## Verification
The bench drives an INCR burst whose start address is unaligned but whose size-aligned start stays inside the 4KB page. A monitor that computed the end address from the raw address would report a false crossing there. It drives a WRAP burst that is aligned but three beats long, and one that has a legal length but is misaligned; a design that merged the two rules would set both bits. The READY wait is held for exactly MAX_WAITS−1 cycles and then for MAX_WAITS cycles, which exposes an off-by-one in the warning counter. Two payload fields change in the same cycle to test that the lower index wins in `first_err_o`, and a field changes right after an accepted handshake to test that this raises no error. A behavioural model compares all outputs on every cycle.

// File: rtl/amon_pkg.sv
package amon_pkg;
  typedef enum int unsigned {
    RULE_RST_VALID  = 0,
    RULE_VALID_DROP = 1,
    RULE_ID_HOLD    = 2,
    RULE_ADDR_HOLD  = 3,
    RULE_LEN_HOLD   = 4,
    RULE_SIZE_HOLD  = 5,
    RULE_BURST_HOLD = 6,
    RULE_LOCK_HOLD  = 7,
    RULE_CACHE_HOLD = 8,
    RULE_PROT_HOLD  = 9,
    RULE_BURST_ENC  = 10,
    RULE_LOCK_ENC   = 11,
    RULE_CACHE_ENC  = 12,
    RULE_SIZE_WIDE  = 13,
    RULE_WRAP_ALIGN = 14,
    RULE_WRAP_LEN   = 15,
    RULE_4K_CROSS   = 16
  } rule_e;

  localparam int unsigned NUM_RULES = 17;
  localparam int unsigned NUM_HOLD  = 10;
  localparam int unsigned NUM_GEOM  = NUM_RULES - NUM_HOLD;

  localparam logic [1:0] BURST_FIXED = 2'b00;
  localparam logic [1:0] BURST_INCR  = 2'b01;
  localparam logic [1:0] BURST_WRAP  = 2'b10;
endpackage

// File: rtl/amon_hold_check.sv
module amon_hold_check
  import amon_pkg::*;
#(
  parameter int unsigned ID_W   = 4,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              ready_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        len_i,
  input  logic [2:0]        size_i,
  input  logic [1:0]        burst_i,
  input  logic [1:0]        lock_i,
  input  logic [3:0]        cache_i,
  input  logic [2:0]        prot_i,
  output logic [NUM_HOLD-1:0] viol_o
);
  logic              first_cyc_q;
  logic              pend_q;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        len_q;
  logic [2:0]        size_q;
  logic [1:0]        burst_q;
  logic [1:0]        lock_q;
  logic [3:0]        cache_q;
  logic [2:0]        prot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_cyc_q <= 1'b1;
      pend_q      <= 1'b0;
      id_q        <= '0;
      addr_q      <= '0;
      len_q       <= '0;
      size_q      <= '0;
      burst_q     <= '0;
      lock_q      <= '0;
      cache_q     <= '0;
      prot_q      <= '0;
    end else begin
      first_cyc_q <= 1'b0;
      pend_q      <= valid_i & ~ready_i;
      id_q        <= id_i;
      addr_q      <= addr_i;
      len_q       <= len_i;
      size_q      <= size_i;
      burst_q     <= burst_i;
      lock_q      <= lock_i;
      cache_q     <= cache_i;
      prot_q      <= prot_i;
    end
  end

  // checks apply only while a previously offered request is still waiting
  logic held;
  assign held = pend_q & valid_i;

  always_comb begin
    viol_o                  = '0;
    viol_o[RULE_RST_VALID]  = first_cyc_q & valid_i;
    viol_o[RULE_VALID_DROP] = pend_q & ~valid_i;
    viol_o[RULE_ID_HOLD]    = held & (id_i    != id_q);
    viol_o[RULE_ADDR_HOLD]  = held & (addr_i  != addr_q);
    viol_o[RULE_LEN_HOLD]   = held & (len_i   != len_q);
    viol_o[RULE_SIZE_HOLD]  = held & (size_i  != size_q);
    viol_o[RULE_BURST_HOLD] = held & (burst_i != burst_q);
    viol_o[RULE_LOCK_HOLD]  = held & (lock_i  != lock_q);
    viol_o[RULE_CACHE_HOLD] = held & (cache_i != cache_q);
    viol_o[RULE_PROT_HOLD]  = held & (prot_i  != prot_q);
  end
endmodule

// File: rtl/amon_geom_check.sv
module amon_geom_check
  import amon_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        len_i,
  input  logic [2:0]        size_i,
  input  logic [1:0]        burst_i,
  input  logic [1:0]        lock_i,
  input  logic [3:0]        cache_i,
  output logic [NUM_GEOM-1:0] viol_o
);
  localparam int unsigned BUS_BYTES = DATA_W / 8;
  localparam int unsigned MAX_SIZE  = $clog2(BUS_BYTES);
  localparam int unsigned PAGE_BITS = 12;

  logic [ADDR_W-1:0] lane_mask;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W:0]   span;
  logic [ADDR_W:0]   last_byte;
  logic              is_wrap, is_incr, wrap_len_ok, crosses;

  assign lane_mask   = (ADDR_W'(1) << size_i) - ADDR_W'(1);
  assign base        = addr_i & ~lane_mask;
  assign span        = ((ADDR_W+1)'(len_i) + (ADDR_W+1)'(1)) << size_i;
  assign last_byte   = {1'b0, base} + span - (ADDR_W+1)'(1);
  assign crosses     = (last_byte >> PAGE_BITS) != ({1'b0, base} >> PAGE_BITS);
  assign is_wrap     = burst_i == BURST_WRAP;
  assign is_incr     = burst_i == BURST_INCR;
  assign wrap_len_ok = (len_i == 4'd1) | (len_i == 4'd3) | (len_i == 4'd7) | (len_i == 4'd15);

  always_comb begin
    viol_o = '0;
    viol_o[RULE_BURST_ENC  - NUM_HOLD] = valid_i & (burst_i == 2'b11);
    viol_o[RULE_LOCK_ENC   - NUM_HOLD] = valid_i & (lock_i == 2'b11);
    viol_o[RULE_CACHE_ENC  - NUM_HOLD] = valid_i & ~cache_i[1] & (|cache_i[3:2]);
    viol_o[RULE_SIZE_WIDE  - NUM_HOLD] = valid_i & (32'(size_i) > MAX_SIZE);
    viol_o[RULE_WRAP_ALIGN - NUM_HOLD] = valid_i & is_wrap & (|(addr_i & lane_mask));
    viol_o[RULE_WRAP_LEN   - NUM_HOLD] = valid_i & is_wrap & ~wrap_len_ok;
    viol_o[RULE_4K_CROSS   - NUM_HOLD] = valid_i & is_incr & crosses;
  end
endmodule

// File: rtl/amon_wait_timer.sv
module amon_wait_timer #(
  parameter int unsigned MAX_WAITS    = 16,
  parameter bit          WAIT_WARN_EN = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic ready_i,
  output logic warn_o
);
  localparam int unsigned CW = $clog2(MAX_WAITS) + 1;

  generate
    if (WAIT_WARN_EN) begin : g_timer
      logic [CW-1:0] cnt_q;
      logic          warn_q;
      logic          waiting;
      assign waiting = valid_i & ~ready_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q  <= '0;
          warn_q <= 1'b0;
        end else begin
          if (!waiting) cnt_q <= '0;
          else if (cnt_q != CW'(MAX_WAITS - 1)) cnt_q <= cnt_q + CW'(1);
          if (waiting && cnt_q == CW'(MAX_WAITS - 1)) warn_q <= 1'b1;
        end
      end
      assign warn_o = warn_q;

      assert_warn_cause_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(warn_q) |-> $past(valid_i && !ready_i));
    end else begin : g_off
      assign warn_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/amon_err_log.sv
module amon_err_log #(
  parameter int unsigned N = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] viol_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] err_o,
  output logic [N-1:0] first_o
);
  logic [N-1:0] live, pick, err_q, first_q;

  assign live = viol_i & ~mask_i;

  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (live[i]) pick = N'(1) << i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= '0;
      first_q <= '0;
    end else begin
      err_q <= err_q | live;
      if (first_q == '0) first_q <= pick;
    end
  end

  assign err_o   = err_q;
  assign first_o = first_q;

  assert_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q & $past(err_q)) == $past(err_q));
  assert_first_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(first_q));
  assert_first_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_q != '0) |=> (first_q == $past(first_q)));
  assert_first_in_err_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_q & ~err_q) == '0);
endmodule

// File: rtl/addr_chan_monitor.sv
module addr_chan_monitor
  import amon_pkg::*;
#(
  parameter int unsigned ID_W         = 4,
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned DATA_W       = 64,
  parameter int unsigned MAX_WAITS    = 16,
  parameter bit          WAIT_WARN_EN = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 ready_i,
  input  logic [ID_W-1:0]      id_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [3:0]           len_i,
  input  logic [2:0]           size_i,
  input  logic [1:0]           burst_i,
  input  logic [1:0]           lock_i,
  input  logic [3:0]           cache_i,
  input  logic [2:0]           prot_i,
  input  logic [NUM_RULES-1:0] err_mask_i,
  output logic [NUM_RULES-1:0] err_o,
  output logic [NUM_RULES-1:0] first_err_o,
  output logic                 wait_warn_o
);
  logic [NUM_HOLD-1:0]  hold_viol;
  logic [NUM_GEOM-1:0]  geom_viol;
  logic [NUM_RULES-1:0] viol;

  amon_hold_check #(.ID_W(ID_W), .ADDR_W(ADDR_W)) i_hold (
    .clk_i, .rst_ni, .valid_i, .ready_i, .id_i, .addr_i, .len_i, .size_i,
    .burst_i, .lock_i, .cache_i, .prot_i, .viol_o(hold_viol)
  );

  amon_geom_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_geom (
    .valid_i, .addr_i, .len_i, .size_i, .burst_i, .lock_i, .cache_i,
    .viol_o(geom_viol)
  );

  assign viol = {geom_viol, hold_viol};

  amon_err_log #(.N(NUM_RULES)) i_log (
    .clk_i, .rst_ni, .viol_i(viol), .mask_i(err_mask_i),
    .err_o, .first_o(first_err_o)
  );

  amon_wait_timer #(.MAX_WAITS(MAX_WAITS), .WAIT_WARN_EN(WAIT_WARN_EN)) i_wait (
    .clk_i, .rst_ni, .valid_i, .ready_i, .warn_o(wait_warn_o)
  );

  assert_drop_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i && !ready_i) && !valid_i && !err_mask_i[RULE_VALID_DROP])
    |=> err_o[RULE_VALID_DROP]);
  assert_masked_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(err_mask_i) && $past(err_o) == '0) |-> ((err_o & err_mask_i) == '0));
endmodule

// File: tb/test_addr_chan_monitor.sv
`timescale 1ns/1ps
module test_addr_chan_monitor;
  localparam int NR   = 17;
  localparam int MAXW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid, ready;
  logic [3:0]  id;
  logic [31:0] addr;
  logic [3:0]  len;
  logic [2:0]  size;
  logic [1:0]  burst, lock;
  logic [3:0]  cache;
  logic [2:0]  prot;
  logic [NR-1:0] mask;
  logic [NR-1:0] err, first;
  logic warn;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  addr_chan_monitor #(.ID_W(4), .ADDR_W(32), .DATA_W(64), .MAX_WAITS(MAXW)) i_addr_chan_monitor (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ready_i(ready), .id_i(id),
    .addr_i(addr), .len_i(len), .size_i(size), .burst_i(burst), .lock_i(lock),
    .cache_i(cache), .prot_i(prot), .err_mask_i(mask), .err_o(err),
    .first_err_o(first), .wait_warn_o(warn)
  );

  // behavioural reference
  logic [NR-1:0] m_err, m_first, mv;
  logic m_warn, m_fc, m_pv, m_pr;
  int m_wc;
  logic [3:0] p_id; logic [31:0] p_addr; logic [3:0] p_len; logic [2:0] p_size;
  logic [1:0] p_burst, p_lock; logic [3:0] p_cache; logic [2:0] p_prot;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_err = '0; m_first = '0; m_warn = 0; m_wc = 0; m_fc = 1; m_pv = 0; m_pr = 0;
    end else begin
      mv = '0;
      if (m_fc && valid) mv[0] = 1;
      if (m_pv && !m_pr && !valid) mv[1] = 1;
      if (m_pv && !m_pr && valid) begin
        if (id != p_id) mv[2] = 1;
        if (addr != p_addr) mv[3] = 1;
        if (len != p_len) mv[4] = 1;
        if (size != p_size) mv[5] = 1;
        if (burst != p_burst) mv[6] = 1;
        if (lock != p_lock) mv[7] = 1;
        if (cache != p_cache) mv[8] = 1;
        if (prot != p_prot) mv[9] = 1;
      end
      if (valid) begin
        longint bytes, st, en;
        bytes = longint'(1) << size;
        if (burst == 2'b11) mv[10] = 1;
        if (lock == 2'b11) mv[11] = 1;
        if (!cache[1] && cache[3:2] != 0) mv[12] = 1;
        if (bytes > 8) mv[13] = 1;
        if (burst == 2'b10 && (longint'(addr) % bytes) != 0) mv[14] = 1;
        if (burst == 2'b10 && !(len == 1 || len == 3 || len == 7 || len == 15)) mv[15] = 1;
        if (burst == 2'b01) begin
          st = (longint'(addr) / bytes) * bytes;
          en = st + (longint'(len) + 1) * bytes - 1;
          if ((st / 4096) != (en / 4096)) mv[16] = 1;
        end
      end
      if (valid && !ready) begin
        m_wc++;
        if (m_wc >= MAXW) m_warn = 1;
      end else m_wc = 0;
      mv = mv & ~mask;
      m_err = m_err | mv;
      if (m_first == 0) begin
        for (int i = NR - 1; i >= 0; i--) if (mv[i]) m_first = '0 | (NR'(1) << i);
      end
      m_fc = 0; m_pv = valid; m_pr = ready;
      p_id = id; p_addr = addr; p_len = len; p_size = size;
      p_burst = burst; p_lock = lock; p_cache = cache; p_prot = prot;
    end
  end

  task automatic chk(input string tag, input logic [NR-1:0] act, input logic [NR-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one clock; compare every output with the model away from the edge
  task automatic step();
    @(negedge clk);
    chk("model err", err, m_err);
    chk("model first", first, m_first);
    chk("model warn", NR'(warn), NR'(m_warn));
  endtask

  task automatic idle();
    valid = 0; ready = 0; id = 0; addr = 0; len = 0; size = 3'd2;
    burst = 2'b01; lock = 0; cache = 0; prot = 0;
  endtask

  task automatic put(input logic [31:0] a, input logic [3:0] l, input logic [2:0] s,
                     input logic [1:0] b, input logic r);
    valid = 1; ready = r; addr = a; len = l; size = s; burst = b;
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 0; idle();
    step(); step();
    rst_n = 1;
  endtask

  initial begin
    mask = '0; idle();
    // R1 reset and idle
    reset_dut();
    chk("R1 err in reset cycle", err, '0);
    idle(); step();
    chk("R1 err", err, '0); chk("R1 first", first, '0); chk("R1 warn", NR'(warn), '0);

    // R2 valid in first cycle
    reset_dut(); put(32'h100, 0, 2, 2'b01, 1); step();
    chk("R2 err", err, NR'(1)); chk("R2 first", first, NR'(1));
    idle(); step(); step(); step();
    chk("R1 sticky", err, NR'(1));

    // clean traffic, change after accept allowed (R4)
    reset_dut(); idle(); step();
    put(32'h100, 3, 2, 2'b01, 0); step(); step();
    ready = 1; step();
    put(32'h200, 7, 3, 2'b01, 1); id = 4'h3; step();
    idle(); step();
    chk("R4 no error after accept", err, '0);

    // R3 valid drop
    reset_dut(); idle(); step();
    put(32'h40, 1, 2, 2'b01, 0); step();
    valid = 0; step();
    chk("R3 drop", err, NR'(1) << 1); chk("R3 first", first, NR'(1) << 1);

    // R4 two fields change at once, R11 lowest wins
    reset_dut(); idle(); step();
    put(32'h40, 1, 2, 2'b01, 0); step();
    len = 4'd5; prot = 3'h2; step();
    chk("R4 len+prot", err, (NR'(1) << 4) | (NR'(1) << 9));
    chk("R11 lowest index", first, NR'(1) << 4);
    reset_dut(); idle(); step();
    put(32'h40, 1, 2, 2'b01, 0); step();
    id = 4'h1; step();
    chk("R4 id", err, NR'(1) << 2);

    // R5 encodings
    reset_dut(); idle(); step();
    burst = 2'b11; lock = 2'b11; step();
    chk("R5 ignored when idle", err, '0);
    valid = 1; ready = 1; step();
    chk("R5 burst+lock", err, (NR'(1) << 10) | (NR'(1) << 11));
    chk("R11 tie", first, NR'(1) << 10);

    // R6 cache
    reset_dut(); idle(); step();
    put(32'h0, 0, 2, 2'b01, 1); cache = 4'b0110; step();
    chk("R6 legal", err, '0);
    cache = 4'b1000; step();
    chk("R6 illegal", err, NR'(1) << 12);

    // R7 size
    reset_dut(); idle(); step();
    put(32'h0, 0, 3, 2'b01, 1); step();
    chk("R7 bus width ok", err, '0);
    size = 3'd4; step();
    chk("R7 too wide", err, NR'(1) << 13);

    // R8 wrap
    reset_dut(); idle(); step();
    put(32'h1004, 3, 2, 2'b10, 1); step();
    chk("R8 legal wrap", err, '0);
    addr = 32'h1002; step();
    chk("R8 misaligned", err, NR'(1) << 14);
    reset_dut(); idle(); step();
    put(32'h1000, 2, 2, 2'b10, 1); step();
    chk("R8 bad length", err, NR'(1) << 15);

    // R9 4KB crossing
    reset_dut(); idle(); step();
    put(32'hFFC, 0, 3, 2'b01, 1); step();
    chk("R9 unaligned start in page", err, '0);
    put(32'hFF8, 0, 3, 2'b01, 1); step();
    chk("R9 last beat of page", err, '0);
    put(32'hFF8, 1, 3, 2'b01, 1); step();
    chk("R9 cross", err, NR'(1) << 16);
    reset_dut(); idle(); step();
    put(32'hFF8, 15, 3, 2'b00, 1); step();
    put(32'hFF8, 1, 3, 2'b10, 1); step();
    chk("R9 fixed and wrap exempt", err, '0);

    // R10 mask
    reset_dut(); mask = NR'(1) << 16; idle(); step();
    put(32'hFF8, 1, 3, 2'b01, 1); step();
    chk("R10 masked err", err, '0); chk("R10 masked first", first, '0);
    burst = 2'b11; step();
    chk("R10 first skips masked", first, NR'(1) << 10);
    mask = '0;

    // R12 wait warning
    reset_dut(); idle(); step();
    put(32'h80, 0, 2, 2'b01, 0);
    repeat (MAXW - 1) step();
    chk("R12 below limit", NR'(warn), '0);
    ready = 1; step();
    chk("R12 accepted in time", NR'(warn), '0);
    ready = 0;
    repeat (MAXW) step();
    chk("R12 at limit", NR'(warn), NR'(1));
    idle(); step(); step();
    chk("R12 sticky", NR'(warn), NR'(1));

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule